// File: doc/BRIEF.md
# Serial-Bus Signature Checksum Register

This block is a 16-bit signature register placed beside a small byte-oriented serial slave. Every bit that crosses the serial bus while chip select is low is folded into a maximal-length linear feedback shift register, so that a controller can check a long burst of traffic by reading back two bytes instead of echoing every byte. A mode bit chooses which data line feeds the register: the controller-to-slave line (the default) or the slave-to-controller line.

The slave recognises three things on the bus. The command byte 0x45 requests the checksum, which is then shifted out over 16 serial clocks. The command byte 0x05, followed by a 16-bit word, re-arms the register: two key words set it to all ones and pick the monitored line. A run of 32 consecutive one bits re-arms it to the default line. All other command bytes are ignored by the slave but are still compressed when the incoming line is monitored. The serial pins are sampled by the system clock through synchronizers, so the serial clock must be well below the system clock rate.

Top module: `sig_chk_top`

## Requirements
- R1: After the reset input is released the register holds 0xFFFF and monitors the incoming line, so a first checksum read returns 0xE45E.
- R2: Each step computes, from state q and input bit d: bit0 = d^q15, bit1 = q0, bit2 = q1^q15, bit3 = q2^q15, bit4 = q3, bit5 = q4^q15, bit k = q(k-1) for k = 6..15. Bytes are shifted most significant bit first; from 0xFFFF, 32 zero bits followed by command 0x45 yield 0xABCD.
- R3: Command byte 0x45 makes the block capture the register value after all eight of its bits, then drive that value on spi_miso most significant bit first for the next 16 serial clocks; outside that window spi_miso is 0.
- R4: While the incoming line is monitored, every serial bit with chip select low steps the register, including command bits and readout-clock bits, but not the 16 data bits that follow command 0x05.
- R5: Command 0x05 followed by data word 0x0000 sets the register to 0xFFFF and selects the incoming line.
- R6: Command 0x05 followed by 0xFF00 sets the register to 0xFFFF and selects the outgoing line; command bits then leave the register unchanged, so an immediate read returns 0xFFFF.
- R7: While the outgoing line is monitored, only the 16 bits driven on spi_miso during a readout step the register, each with the bit being driven.
- R8: Command 0x05 followed by any word other than the two keys leaves both the register value and the monitored line unchanged.
- R9: 32 consecutive one bits on spi_mosi with chip select low set the register to 0xFFFF and select the incoming line in either mode; a zero bit restarts the count.
- R10: Serial clocks with chip select high do not step the register, and raising chip select discards a partial byte so the next byte is framed from its first bit.
- R11: A command byte other than 0x45 and 0x05 starts no read or write; in incoming mode its bits are still compressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, data taken on its rising edge |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |

## Verification
The checker watches, on every system clock, that a re-arm lands on 0xFFFF, that the register moves only when a step is granted and then by the feedback equation, that no step is granted with chip select high, during write data, or outside a readout in outgoing mode, and that spi_miso is quiet outside a readout. Whether the framing, command decode, key matching and mode handover produce the right checksum as seen from the pins can only be shown by the bench, which replays transactions against its own software model of the register and compares every 16-bit readout, including the fixed values 0xE45E, 0xABCD and 0xFFFF.

// File: rtl/sig_chk_pkg.sv
package sig_chk_pkg;

  // Serial slave framing phase
  typedef enum logic [1:0] {
    PH_CMD = 2'd0,  // collecting a command byte
    PH_WR  = 2'd1,  // collecting the 16-bit re-arm word
    PH_RD  = 2'd2   // shifting the captured checksum out
  } phase_e;

  // Line feeding the signature register
  typedef enum logic {
    MON_IN  = 1'b0,  // controller-to-slave data
    MON_OUT = 1'b1   // slave-to-controller data
  } mon_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sig_chk_sync.sv
module sig_chk_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] r;
      logic [WIDTH-1:0] r_d;
      if (s == 0) begin : g_first
        assign r_d = d;
      end else begin : g_rest
        assign r_d = g_stage[s-1].r;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= r_d;
      end
    end
  endgenerate

  assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/sig_chk_lfsr.sv
module sig_chk_lfsr #(
  parameter int           W    = 16,
  parameter logic [W-1:0] TAPS = 16'h002D,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         din,
  input  logic         clear,
  output logic [W-1:0] q,
  output logic [W-1:0] q_nxt
);

  logic [W-1:0] q_r;
  logic [W-1:0] shifted;
  logic [W-1:0] fb_mask;

  // Shift up, insert the serial bit at the bottom, fold the top bit into the taps
  always_comb begin
    shifted = {q_r[W-2:0], din};
    fb_mask = q_r[W-1] ? TAPS : '0;
    if (clear)     q_nxt = SEED;
    else if (step) q_nxt = shifted ^ fb_mask;
    else           q_nxt = q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            q_r <= SEED;
    else if (clear | step) q_r <= q_nxt;
  end

  assign q = q_r;

endmodule

// File: rtl/sig_chk_frame.sv
module sig_chk_frame
  import sig_chk_pkg::*;
#(
  parameter int              W        = 16,
  parameter int              CMD_W    = 8,
  parameter logic [CMD_W-1:0] RD_CMD  = 8'h45,
  parameter logic [CMD_W-1:0] WR_CMD  = 8'h05,
  parameter int              WR_W     = 16,
  parameter logic [WR_W-1:0] KEY_IN   = 16'h0000,
  parameter logic [WR_W-1:0] KEY_OUT  = 16'hFF00,
  parameter int              ONES_LEN = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_s,
  input  logic         cs_n_s,
  input  logic         mosi_s,
  input  logic [W-1:0] lfsr_nxt,
  output logic         step,
  output logic         din,
  output logic         clear,
  output logic         miso,
  output logic         in_rd,
  output logic         in_wr,
  output logic         mode_out
);

  localparam int CNT_MAX = max3(W, CMD_W, WR_W);
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam int ONES_W  = $clog2(ONES_LEN);
  localparam logic [CNT_W-1:0]  CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0]  WR_LAST   = CNT_W'(WR_W - 1);
  localparam logic [CNT_W-1:0]  RD_LAST   = CNT_W'(W - 1);
  localparam logic [ONES_W-1:0] ONES_LAST = ONES_W'(ONES_LEN - 1);

  // Registers
  logic              sclk_d_q;
  phase_e            phase_q,  phase_d;
  mon_e              mode_q,   mode_d;
  logic [CNT_W-1:0]  cnt_q,    cnt_d;
  logic [CMD_W-1:0]  cmd_sh_q, cmd_sh_d;
  logic [WR_W-1:0]   wr_sh_q,  wr_sh_d;
  logic [W-1:0]      shadow_q, shadow_d;
  logic [ONES_W-1:0] ones_q,   ones_d;

  // Combinational helpers
  logic             act;
  logic [CMD_W-1:0] cmd_word;
  logic [WR_W-1:0]  wr_word;
  logic             ones_hit;
  logic             wr_done;
  logic             key_in_hit;
  logic             key_out_hit;

  assign act      = sclk_s & ~sclk_d_q & ~cs_n_s;
  assign cmd_word = {cmd_sh_q[CMD_W-2:0], mosi_s};
  assign wr_word  = {wr_sh_q[WR_W-2:0], mosi_s};
  assign ones_hit = act & mosi_s & (ones_q == ONES_LAST);
  assign wr_done  = act & (phase_q == PH_WR) & (cnt_q == WR_LAST);
  assign key_in_hit  = wr_done & (wr_word == KEY_IN);
  assign key_out_hit = wr_done & (wr_word == KEY_OUT);

  // Step grant: incoming mode folds all bits except write data,
  // outgoing mode folds only the bits being driven during a readout
  always_comb begin
    step = 1'b0;
    if (act) begin
      if (mode_q == MON_IN) step = (phase_q != PH_WR);
      else                  step = (phase_q == PH_RD);
    end
    din   = (mode_q == MON_OUT) ? shadow_q[W-1] : mosi_s;
    clear = ones_hit | key_in_hit | key_out_hit;
  end

  // Consecutive-ones counter for the serial re-arm
  always_comb begin
    ones_d = ones_q;
    if (act) begin
      if (!mosi_s)       ones_d = '0;
      else if (ones_hit) ones_d = '0;
      else               ones_d = ones_q + 1'b1;
    end
  end

  // Monitored-line selection
  always_comb begin
    mode_d = mode_q;
    if (ones_hit | key_in_hit) mode_d = MON_IN;
    else if (key_out_hit)      mode_d = MON_OUT;
  end

  // Framing and command decode
  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    cmd_sh_d = cmd_sh_q;
    wr_sh_d  = wr_sh_q;
    shadow_d = shadow_q;
    if (cs_n_s) begin
      phase_d = PH_CMD;
      cnt_d   = '0;
    end else if (act) begin
      if (ones_hit) begin
        phase_d = PH_CMD;
        cnt_d   = '0;
      end else begin
        unique case (phase_q)
          PH_CMD: begin
            cmd_sh_d = cmd_word;
            if (cnt_q == CMD_LAST) begin
              cnt_d = '0;
              if (cmd_word == RD_CMD) begin
                phase_d  = PH_RD;
                shadow_d = lfsr_nxt;
              end else if (cmd_word == WR_CMD) begin
                phase_d = PH_WR;
              end
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          PH_WR: begin
            wr_sh_d = wr_word;
            if (cnt_q == WR_LAST) begin
              phase_d = PH_CMD;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          PH_RD: begin
            shadow_d = {shadow_q[W-2:0], 1'b0};
            if (cnt_q == RD_LAST) begin
              phase_d = PH_CMD;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          default: begin
            phase_d = PH_CMD;
            cnt_d   = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      phase_q  <= PH_CMD;
      mode_q   <= MON_IN;
      cnt_q    <= '0;
      cmd_sh_q <= '0;
      wr_sh_q  <= '0;
      shadow_q <= '0;
      ones_q   <= '0;
    end else begin
      sclk_d_q <= sclk_s;
      phase_q  <= phase_d;
      mode_q   <= mode_d;
      cnt_q    <= cnt_d;
      cmd_sh_q <= cmd_sh_d;
      wr_sh_q  <= wr_sh_d;
      shadow_q <= shadow_d;
      ones_q   <= ones_d;
    end
  end

  assign miso     = (phase_q == PH_RD) & shadow_q[W-1];
  assign in_rd    = (phase_q == PH_RD);
  assign in_wr    = (phase_q == PH_WR);
  assign mode_out = (mode_q == MON_OUT);

endmodule

// File: rtl/sig_chk_top.sv
module sig_chk_top #(
  parameter int                LFSR_W      = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK    = 16'h002D,
  parameter int                CMD_W       = 8,
  parameter logic [CMD_W-1:0]  RD_CMD      = 8'h45,
  parameter logic [CMD_W-1:0]  WR_CMD      = 8'h05,
  parameter int                WR_W        = 16,
  parameter logic [WR_W-1:0]   KEY_IN      = 16'h0000,
  parameter logic [WR_W-1:0]   KEY_OUT     = 16'hFF00,
  parameter int                ONES_LEN    = 32,
  parameter int                SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);

  localparam logic [LFSR_W-1:0] SEED = '1;

  logic              rst_sn;
  logic [2:0]        pins_s;
  logic              sclk_s;
  logic              cs_n_s;
  logic              mosi_s;
  logic              lfsr_step;
  logic              lfsr_din;
  logic              lfsr_clear;
  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] lfsr_nxt;
  logic              in_rd;
  logic              in_wr;
  logic              mode_out;

  // Reset: asserted asynchronously, released on the clock
  sig_chk_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) rst_sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sn)
  );

  // Serial pins into the system clock domain
  sig_chk_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) pin_sync_i (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     ({spi_sclk, spi_cs_n, spi_mosi}),
    .q     (pins_s)
  );

  assign sclk_s = pins_s[2];
  assign cs_n_s = pins_s[1];
  assign mosi_s = pins_s[0];

  sig_chk_frame #(
    .W        (LFSR_W),
    .CMD_W    (CMD_W),
    .RD_CMD   (RD_CMD),
    .WR_CMD   (WR_CMD),
    .WR_W     (WR_W),
    .KEY_IN   (KEY_IN),
    .KEY_OUT  (KEY_OUT),
    .ONES_LEN (ONES_LEN)
  ) frame_i (
    .clk      (clk),
    .rst_n    (rst_sn),
    .sclk_s   (sclk_s),
    .cs_n_s   (cs_n_s),
    .mosi_s   (mosi_s),
    .lfsr_nxt (lfsr_nxt),
    .step     (lfsr_step),
    .din      (lfsr_din),
    .clear    (lfsr_clear),
    .miso     (spi_miso),
    .in_rd    (in_rd),
    .in_wr    (in_wr),
    .mode_out (mode_out)
  );

  sig_chk_lfsr #(.W(LFSR_W), .TAPS(TAP_MASK), .SEED(SEED)) lfsr_i (
    .clk   (clk),
    .rst_n (rst_sn),
    .step  (lfsr_step),
    .din   (lfsr_din),
    .clear (lfsr_clear),
    .q     (lfsr_q),
    .q_nxt (lfsr_nxt)
  );

endmodule

// File: rtl/sig_chk_checker.sv
module sig_chk_checker #(
  parameter int           W    = 16,
  parameter logic [W-1:0] TAPS = 16'h002D
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n_s,
  input logic         step,
  input logic         clear,
  input logic         din,
  input logic [W-1:0] q,
  input logic         miso,
  input logic         in_rd,
  input logic         in_wr,
  input logic         mode_out
);

  // R1 R5 R6 R9: every re-arm lands on all ones
  p_rearm_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (q == '1));

  // R2: a granted step follows the feedback equation
  p_step_eq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear) |=> (q == ({$past(q[W-2:0]), $past(din)} ^ ($past(q[W-1]) ? TAPS : '0))));

  // R10: no step without a grant; no grant with chip select high
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(q));
  p_cs_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> !step);

  // R4: write data bits are never folded in
  p_wr_nostep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_wr |-> !step);

  // R7: outgoing mode folds only readout bits
  p_out_rd_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out && !in_rd) |-> !step);

  // R3: the output line is quiet outside a readout
  p_miso_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rd |-> !miso);

endmodule

bind sig_chk_top sig_chk_checker #(.W(LFSR_W), .TAPS(TAP_MASK)) chk_i (
  .clk      (clk),
  .rst_n    (rst_sn),
  .cs_n_s   (cs_n_s),
  .step     (lfsr_step),
  .clear    (lfsr_clear),
  .din      (lfsr_din),
  .q        (lfsr_q),
  .miso     (spi_miso),
  .in_rd    (in_rd),
  .in_wr    (in_wr),
  .mode_out (mode_out)
);

// File: tb/sig_chk_top_tb_top.sv
module sig_chk_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 8;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    logic [15:0] val;
    string       req;
  } exp_t;

  logic clk;
  logic rst_n;
  logic spi_sclk;
  logic spi_cs_n;
  logic spi_mosi;
  logic spi_miso;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  exp_t        exp_q[$];
  logic [15:0] obs_q[$];

  // Bench model of the register
  logic [15:0] m_q;
  bit          m_out;

  sig_chk_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi),
    .spi_miso (spi_miso)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] m_next(input logic [15:0] q, input logic d);
    logic [15:0] n;
    n[0] = d ^ q[15];
    n[1] = q[0];
    n[2] = q[1] ^ q[15];
    n[3] = q[2] ^ q[15];
    n[4] = q[3];
    n[5] = q[4] ^ q[15];
    for (int k = 6; k < 16; k++) n[k] = q[k-1];
    return n;
  endfunction

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_bit(input logic b, output logic so);
    spi_mosi = b;
    wait_clks(HALF_BIT);
    so = spi_miso;
    spi_sclk = 1'b1;
    wait_clks(HALF_BIT);
    spi_sclk = 1'b0;
  endtask

  task automatic cs_on();
    spi_cs_n = 1'b0;
    wait_clks(4);
  endtask

  task automatic cs_off();
    wait_clks(4);
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    wait_clks(8);
  endtask

  // One byte with chip select low; incoming mode folds every bit (R4, R11)
  task automatic send_byte(input logic [7:0] c, input string req);
    logic so;
    logic [7:0] seen;
    for (int i = 7; i >= 0; i--) begin
      sclk_bit(c[i], so);
      seen[i] = so;
      if (!m_out) m_q = m_next(m_q, c[i]);
    end
    check(seen == 8'h00, req, {8'h00, seen}, 16'h0000);
  endtask

  task automatic tx_cmd(input logic [7:0] c, input string req);
    cs_on();
    send_byte(c, req);
    cs_off();
  endtask

  // Read command 0x45, then 16 readout clocks with zeros on spi_mosi
  task automatic read_ck(input string req, input bit use_const, input logic [15:0] cv);
    logic [15:0] cap;
    logic [15:0] got;
    logic        so;
    exp_t        e;
    cs_on();
    send_byte(8'h45, "R3 command phase quiet");
    cap   = m_q;
    e.val = use_const ? cv : cap;
    e.req = req;
    exp_q.push_back(e);
    for (int i = 15; i >= 0; i--) begin
      sclk_bit(1'b0, so);
      got[i] = so;
      m_q = m_next(m_q, m_out ? cap[i] : 1'b0);
    end
    cs_off();
    obs_q.push_back(got);
  endtask

  // Command 0x05 plus a 16-bit word; data bits never fold in (R4)
  task automatic write_ck(input logic [15:0] w);
    logic so;
    cs_on();
    send_byte(8'h05, "R3 write command quiet");
    for (int i = 15; i >= 0; i--) sclk_bit(w[i], so);
    cs_off();
    if (w == 16'h0000) begin m_q = 16'hFFFF; m_out = 0; end
    else if (w == 16'hFF00) begin m_q = 16'hFFFF; m_out = 1; end
  endtask

  // Scoreboard monitor
  initial begin
    exp_t        e;
    logic [15:0] o;
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        o = obs_q.pop_front();
        check(o == e.val, e.req, o, e.val);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic so;
    spi_sclk = 1'b0;
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    rst_n    = 1'b0;
    m_q      = 16'hFFFF;
    m_out    = 0;
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(10);

    // R3: idle output low after reset
    check(spi_miso == 1'b0, "R3 idle miso", {15'd0, spi_miso}, 16'h0000);

    // R1: first read after reset
    read_ck("R1 reset value read", 1, 16'hE45E);
    // R4: readout clocks and command bits fold in
    read_ck("R4 consecutive read", 0, 16'h0000);

    // R5: key 0x0000 re-arms to incoming mode
    write_ck(16'h0000);
    read_ck("R5 re-arm incoming", 1, 16'hE45E);

    // R2: 32 zero bits then the read command
    write_ck(16'h0000);
    for (int i = 0; i < 4; i++) tx_cmd(8'h00, "R11 zero byte quiet");
    read_ck("R2 zeros signature", 1, 16'hABCD);

    // R11: unknown command is compressed but starts nothing
    tx_cmd(8'h3C, "R11 unknown command quiet");
    read_ck("R11 unknown command folded", 0, 16'h0000);

    // R10: partial byte then clocks with chip select high
    cs_on();
    sclk_bit(1'b1, so); m_q = m_next(m_q, 1'b1);
    sclk_bit(1'b0, so); m_q = m_next(m_q, 1'b0);
    sclk_bit(1'b1, so); m_q = m_next(m_q, 1'b1);
    sclk_bit(1'b0, so); m_q = m_next(m_q, 1'b0);
    cs_off();
    for (int i = 0; i < 8; i++) sclk_bit(1'b1, so);
    spi_mosi = 1'b0;
    read_ck("R10 cs high and reframe", 0, 16'h0000);

    // R6: key 0xFF00 selects outgoing mode
    write_ck(16'hFF00);
    read_ck("R6 outgoing immediate read", 1, 16'hFFFF);
    // R7: driven bits fold in
    read_ck("R7 outgoing second read", 0, 16'h0000);
    // R8: a non-key word changes nothing
    write_ck(16'h1234);
    read_ck("R8 non-key write ignored", 0, 16'h0000);

    // R9: 32 ones re-arm from outgoing mode
    cs_on();
    for (int i = 0; i < 4; i++) send_byte(8'hFF, "R9 ones quiet");
    cs_off();
    m_q = 16'hFFFF;
    m_out = 0;
    read_ck("R9 ones re-arm", 1, 16'hE45E);

    // R9: a zero bit breaks the run
    write_ck(16'h0000);
    tx_cmd(8'hFF, "R9 run quiet");
    tx_cmd(8'hFF, "R9 run quiet");
    tx_cmd(8'hFF, "R9 run quiet");
    tx_cmd(8'hFE, "R9 run quiet");
    read_ck("R9 broken run no re-arm", 0, 16'h0000);

    wait_clks(20);
    check(exp_q.size() == 0 && obs_q.size() == 0, "scoreboard drained",
          16'(obs_q.size()), 16'(exp_q.size()));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule